// File: doc/BRIEF.md
# If-Then Predication Window Sequencer

This block follows a short run of predicated instructions opened by an if-then instruction. When the if-then instruction is seen, the decoder raises `it_start_i` with a 4-bit base condition code and a 4-bit then/else mask. For every later instruction that issues while the window is open, the block gives the condition that applies to that slot and says whether the instruction executes. The answer comes from evaluating that condition against the N, Z, C and V flags present in the issue cycle. A failing slot is dropped in place, with no branch. Outside a window every instruction executes.

The mask holds one letter per slot after the first, starting at the most significant bit, and then a single terminating 1. The first slot always uses the base condition. A then slot (letter 0) also uses the base condition. An else slot (letter 1) uses its inverse. The block is purely combinational from its state registers and flag inputs to its outputs, so the decision is ready in the same cycle as the issue.

Top module: `it_seq`

## Requirements
- R1: After reset, no window is open, `in_window_o` is 0, `exec_en_o` is 1 and `cur_cond_o` is 14 (always).
- R2: `it_start_i` with a nonzero mask opens a window from the next cycle. The first slot reports the base condition. The window holds (4 minus the bit index of the lowest set mask bit) slots, so mask 1000b gives 1 slot and xyz1b gives 4.
- R3: The mask letters are used from bit 3 downward, one per slot after the first. Letter 0 selects the base condition and letter 1 selects its inverse.
- R4: Issuing the last slot of a window closes it. From the next cycle `in_window_o` is 0.
- R5: While a window is open, a cycle without `issue_i` leaves the current slot, its condition and the window unchanged.
- R6: Condition codes: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 Z|(N!=V); 12 !Z&(N==V); 13 N!=V; 14 and 15 always true.
- R7: The inverse of a condition pairs 0/1, 2/3, 4/5, 6/7 and 8/9, swaps 10 with 13 and 11 with 12, and leaves 14 and 15 as themselves.
- R8: `exec_en_o` uses the flag inputs of the cycle it is read in. A slot whose flags were changed by an earlier slot sees the new values.
- R9: `it_start_i` while a window is open restarts it with the new condition and mask. An `issue_i` in the same cycle as `it_start_i` never advances a slot.
- R10: `it_start_i` with mask 0000b is ignored. Window state and outputs carry on as if it were absent.
- R11: With no window open, `exec_en_o` is 1 and `cur_cond_o` is 14 whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| it_start_i | input | 1 | If-then instruction seen this cycle |
| it_cond_i | input | 4 | Base condition code |
| it_mask_i | input | 4 | Then/else letters with trailing 1 terminator |
| issue_i | input | 1 | An instruction issues this cycle |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| exec_en_o | output | 1 | Current instruction executes |
| in_window_o | output | 1 | A predication window is open |
| cur_cond_o | output | 4 | Condition applied to the current slot |

## Verification
Single-slot windows are opened for every condition code against all sixteen flag combinations. This separates each code's formula from its neighbours. Two-slot windows with an else second slot repeat that sweep, so an inversion table that pairs the signed codes wrongly shows up. Four- and three-slot windows with mixed letters and flags that change between slots separate correct MSB-first letter use and live flag sampling from off-by-one shifting. Idle cycles, restarts with a simultaneous issue, and zero-mask starts are also applied. They tell holding apart from advancing, and a real restart apart from an ignored one.

// File: rtl/it_seq_pkg.sv
`timescale 1ns/1ps
package it_seq_pkg;
  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_CS = 4'd2;
  localparam logic [3:0] CC_CC = 4'd3;
  localparam logic [3:0] CC_MI = 4'd4;
  localparam logic [3:0] CC_PL = 4'd5;
  localparam logic [3:0] CC_VS = 4'd6;
  localparam logic [3:0] CC_VC = 4'd7;
  localparam logic [3:0] CC_HI = 4'd8;
  localparam logic [3:0] CC_LS = 4'd9;
  localparam logic [3:0] CC_GE = 4'd10;
  localparam logic [3:0] CC_LE = 4'd11;
  localparam logic [3:0] CC_GT = 4'd12;
  localparam logic [3:0] CC_LT = 4'd13;
  localparam logic [3:0] CC_AL = 4'd14;
  localparam logic [3:0] CC_NV = 4'd15;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // signed group is not adjacent-paired, so the low-bit flip fails there
  function automatic logic [3:0] cc_invert(input logic [3:0] cc);
    logic [3:0] r;
    case (cc)
      CC_GE:   r = CC_LT;
      CC_LT:   r = CC_GE;
      CC_LE:   r = CC_GT;
      CC_GT:   r = CC_LE;
      CC_AL:   r = CC_AL;
      CC_NV:   r = CC_NV;
      default: r = {cc[3:1], ~cc[0]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/it_cond_eval.sv
`timescale 1ns/1ps
module it_cond_eval
  import it_seq_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic sgn_eq;
  assign sgn_eq = (flags_i.n == flags_i.v);

  always_comb begin
    case (cond_i)
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = ~flags_i.z;
      CC_CS:   pass_o = flags_i.c;
      CC_CC:   pass_o = ~flags_i.c;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = ~flags_i.n;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = ~flags_i.v;
      CC_HI:   pass_o = flags_i.c & ~flags_i.z;
      CC_LS:   pass_o = ~flags_i.c | flags_i.z;
      CC_GE:   pass_o = sgn_eq;
      CC_LE:   pass_o = flags_i.z | ~sgn_eq;
      CC_GT:   pass_o = ~flags_i.z & sgn_eq;
      CC_LT:   pass_o = ~sgn_eq;
      default: pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/it_window.sv
`timescale 1ns/1ps
module it_window
  import it_seq_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       cond_i,
  input  logic [SLOTS-1:0] mask_i,
  input  logic             issue_i,
  output logic             active_o,
  output logic             else_o,
  output logic [3:0]       base_o
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [SLOTS-1:0] TERM = {1'b1, {(SLOTS-1){1'b0}}};

  logic             active_q, else_q;
  logic [3:0]       base_q;
  logic [SLOTS-1:0] rem_q;
  logic [CNT_W-1:0] adv_q;
  logic             load, step;

  assign load = start_i && (mask_i != '0);
  assign step = !start_i && issue_i && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      else_q   <= 1'b0;
      base_q   <= CC_AL;
      rem_q    <= '0;
      adv_q    <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      else_q   <= 1'b0;
      base_q   <= cond_i;
      rem_q    <= mask_i;
      adv_q    <= '0;
    end else if (step) begin
      if (rem_q == TERM) begin
        active_q <= 1'b0;
      end else begin
        else_q <= rem_q[SLOTS-1];
        rem_q  <= {rem_q[SLOTS-2:0], 1'b0};
        adv_q  <= adv_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign else_o   = else_q;
  assign base_o   = base_q;

  assert_slot_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_q <= CNT_W'(SLOTS - 1));

  assert_close_on_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(issue_i) && !$past(start_i));
endmodule

// File: rtl/it_seq.sv
`timescale 1ns/1ps
module it_seq
  import it_seq_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             it_start_i,
  input  logic [3:0]       it_cond_i,
  input  logic [SLOTS-1:0] it_mask_i,
  input  logic             issue_i,
  input  logic             flag_n_i,
  input  logic             flag_z_i,
  input  logic             flag_c_i,
  input  logic             flag_v_i,
  output logic             exec_en_o,
  output logic             in_window_o,
  output logic [3:0]       cur_cond_o
);
  logic       active, slot_else;
  logic [3:0] base;
  flags_t     flags;

  assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

  it_window #(.SLOTS(SLOTS)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (it_start_i),
    .cond_i  (it_cond_i),
    .mask_i  (it_mask_i),
    .issue_i (issue_i),
    .active_o(active),
    .else_o  (slot_else),
    .base_o  (base)
  );

  always_comb begin
    if (!active)        cur_cond_o = CC_AL;
    else if (slot_else) cur_cond_o = cc_invert(base);
    else                cur_cond_o = base;
  end

  it_cond_eval u_eval (
    .cond_i (cur_cond_o),
    .flags_i(flags),
    .pass_o (exec_en_o)
  );

  assign in_window_o = active;

  assert_idle_exec_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_window_o |-> exec_en_o && (cur_cond_o == CC_AL));

  assert_first_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (it_start_i && it_mask_i != '0) |=> in_window_o && (cur_cond_o == $past(it_cond_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_window_o && !issue_i && !it_start_i) |=> in_window_o && $stable(cur_cond_o));

  assert_zero_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (it_start_i && it_mask_i == '0 && !issue_i) |=> $stable(in_window_o) && $stable(cur_cond_o));

  assert_always_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_cond_o == CC_AL || cur_cond_o == CC_NV) |-> exec_en_o);
endmodule

// File: tb/it_seq_test.sv
`timescale 1ns/1ps
module it_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st = 1'b0;
  logic [3:0] cc = 4'd0;
  logic [3:0] mk = 4'd0;
  logic       iss = 1'b0;
  logic [3:0] fl = 4'd0;  // {n,z,c,v}
  logic       ex, win;
  logic [3:0] cur;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  it_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .it_start_i(st), .it_cond_i(cc), .it_mask_i(mk),
    .issue_i(iss), .flag_n_i(fl[3]), .flag_z_i(fl[2]), .flag_c_i(fl[1]), .flag_v_i(fl[0]),
    .exec_en_o(ex), .in_window_o(win), .cur_cond_o(cur)
  );

  typedef struct {
    logic       ex;
    logic       win;
    logic [3:0] cc;
    string      req;
  } exp_t;
  exp_t sb[$];

  // reference model, written from the requirement text
  logic       m_act = 1'b0;
  logic       m_els = 1'b0;
  logic [3:0] m_base = 4'd14;
  logic [3:0] m_rem = 4'd0;

  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    if (c == 0) return z;
    if (c == 1) return !z;
    if (c == 2) return cy;
    if (c == 3) return !cy;
    if (c == 4) return n;
    if (c == 5) return !n;
    if (c == 6) return v;
    if (c == 7) return !v;
    if (c == 8) return cy && !z;
    if (c == 9) return !cy || z;
    if (c == 10) return n == v;
    if (c == 11) return z || (n != v);
    if (c == 12) return !z && (n == v);
    if (c == 13) return n != v;
    return 1'b1;
  endfunction

  function automatic logic [3:0] ref_inv(input logic [3:0] c);
    if (c == 10) return 4'd13;
    if (c == 13) return 4'd10;
    if (c == 11) return 4'd12;
    if (c == 12) return 4'd11;
    if (c >= 14) return c;
    return (c % 2 == 0) ? c + 4'd1 : c - 4'd1;
  endfunction

  task automatic step(input logic s, input logic [3:0] c, input logic [3:0] m,
                      input logic i, input logic [3:0] f, input string req);
    exp_t e;
    @(negedge clk);
    st = s; cc = c; mk = m; iss = i; fl = f;
    e.win = m_act;
    e.cc  = !m_act ? 4'd14 : (m_els ? ref_inv(m_base) : m_base);
    e.ex  = ref_pass(e.cc, f);
    e.req = req;
    sb.push_back(e);
    if (s && m != 0) begin
      m_act = 1'b1; m_els = 1'b0; m_base = c; m_rem = m;
    end else if (!s && i && m_act) begin
      if (m_rem == 4'b1000) m_act = 1'b0;
      else begin m_els = m_rem[3]; m_rem = m_rem << 1; end
    end
  endtask

  task automatic idle(input logic [3:0] f, input string req);
    step(1'b0, 4'd0, 4'd0, 1'b0, f, req);
  endtask

  task automatic issue(input logic [3:0] f, input string req);
    step(1'b0, 4'd0, 4'd0, 1'b1, f, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        e = sb.pop_front();
        n_tests++;
        if (ex !== e.ex || win !== e.win || cur !== e.cc) begin
          n_fail++;
          $display("FAIL %s: got ex=%b win=%b cond=%0d, expected ex=%b win=%b cond=%0d",
                   e.req, ex, win, cur, e.ex, e.win, e.cc);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4'b0000, "R1");
    idle(4'b1111, "R1 R11");

    // R6: every code against every flag set in a one-slot window
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        step(1'b1, 4'(c), 4'b1000, 1'b0, 4'(f), "R2");
        issue(4'(f), "R6");
        idle(4'(f), "R4");
      end

    // R7: second slot is else
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        step(1'b1, 4'(c), 4'b1100, 1'b0, 4'(f), "R2");
        issue(4'(f), "R3");
        issue(4'(f), "R7");
        idle(4'(f), "R4");
      end

    // R3 R8: four slots then,else,then with flags changing per slot
    step(1'b1, 4'd0, 4'b0101, 1'b0, 4'b0000, "R2");
    issue(4'b0100, "R8");
    issue(4'b0000, "R3");
    issue(4'b0100, "R8");
    issue(4'b0000, "R3");
    idle(4'b0000, "R4");

    // three slots, else,else, signed condition
    step(1'b1, 4'd12, 4'b1110, 1'b0, 4'b1001, "R2");
    issue(4'b1001, "R3");
    issue(4'b1000, "R7");
    issue(4'b0000, "R8");
    idle(4'b0000, "R4");

    // R5: hold without issue
    step(1'b1, 4'd8, 4'b1100, 1'b0, 4'b0010, "R2");
    idle(4'b0010, "R5");
    idle(4'b0110, "R5");
    issue(4'b0010, "R5");
    idle(4'b0010, "R5");
    issue(4'b0110, "R7");
    idle(4'b0000, "R4");

    // R9: restart mid-window with same-cycle issue
    step(1'b1, 4'd2, 4'b0001, 1'b0, 4'b0000, "R2");
    issue(4'b0010, "R9");
    step(1'b1, 4'd5, 4'b1000, 1'b1, 4'b0000, "R9");
    issue(4'b1000, "R9");
    idle(4'b0000, "R9");

    // R10: zero mask ignored, inside and outside a window
    step(1'b1, 4'd4, 4'b0000, 1'b0, 4'b0000, "R10");
    idle(4'b0000, "R10");
    step(1'b1, 4'd6, 4'b1100, 1'b0, 4'b0001, "R2");
    step(1'b1, 4'd0, 4'b0000, 1'b0, 4'b0001, "R10");
    issue(4'b0001, "R10");
    issue(4'b0001, "R10");
    idle(4'b0101, "R11");

    // R1: reset in the middle of a window
    step(1'b1, 4'd1, 4'b0001, 1'b0, 4'b0000, "R2");
    issue(4'b0000, "R3");
    @(negedge clk);
    rst_n = 1'b0;
    m_act = 1'b0; m_els = 1'b0; m_base = 4'd14; m_rem = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(4'b0100, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule